// File: doc/BRIEF.md
# Triple-Buffer Frame Slot Arbiter

This block decides which of three frame buffer slots a video write engine and several video read engines use, so that frames can pass between sides running at unrelated frame rates without tearing. The write side leads. Each `wr_frame_done` pulse moves the writer to the next slot in cyclic order and loads that slot's base address. Each read port works in its own clock domain. When its `rd_frame_start` pulse arrives, the port looks at the most recently completed write slot and moves there. Depending on how far the writer has moved, this is a plain advance, a skip (a frame is dropped) or a stay on the same slot (a frame is repeated). The read port is then one frame behind the writer and never on the slot being filled.

Completion of a write frame reaches each read domain through a toggle synchronizer. The index of the completed slot and a snapshot of the address table travel with it as data. That data stays stable from one write frame to the next, so it is captured safely on the synchronized edge. The three base addresses are programmed in the write clock domain. Each side picks up a change only at its own frame boundary. Every read port counts its dropped and repeated frames in saturating counters.

Top module: `tbs_frame_sync`

## Requirements
- R1: After reset the writer is on slot 0 with `wr_addr` equal to table entry 0. Every read port is on slot 2 with `rd_addr` equal to entry 2, and both of its counters are zero.
- R2: Each `wr_frame_done` pulse moves `wr_slot` through 0→1→2→0 on the next `wr_clk` edge. `wr_addr` then becomes the table entry of the new slot. With no pulse, both hold.
- R3: A read port that has not yet received any completed write frame ignores `rd_frame_start`. Its slot, address and counters stay unchanged.
- R4: On `rd_frame_start`, with L the last completed write slot it has received, a read port moves to slot L one `rd_clk` edge later.
  - If L equals its current slot, the frame is repeated and the repeat counter increments.
  - If L is the current slot plus 1 (mod 3), the port advances normally and neither counter changes.
  - If L is the current slot plus 2 (mod 3), a slot is skipped and the drop counter increments.
- R5: After a frame start, a read port's slot never equals the writer's current slot (L+1 mod 3) as that port last saw it.
- R6: Read ports decide independently. A start pulse on one port leaves every other port's slot, address and counters unchanged.
- R7: The drop and repeat counters are CNT_W bits wide and saturate at 2^CNT_W−1.
- R8: A table write (`cfg_we` high, `cfg_idx` 0..2, `cfg_data`) does not change `wr_addr` in the cycle it is made. The writer uses the new value from its next frame completion. A `cfg_idx` of 3 is ignored.
- R9: A read port's `rd_addr` changes only on a frame start. It is taken from the table as it stood at the latest write completion that port has received.
- R10: A write completion is visible to a read port's decision for any start pulse that arrives 6 or more `rd_clk` cycles after the completion's `wr_clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous active-low reset |
| wr_frame_done | input | 1 | One-cycle pulse: writer finished its frame |
| cfg_we | input | 1 | Table write strobe (write clock domain) |
| cfg_idx | input | 2 | Table entry to write; 3 is ignored |
| cfg_data | input | AW | New base address |
| wr_slot | output | 2 | Slot the writer is filling |
| wr_addr | output | AW | Base address of the writer's slot |
| rd_clk | input | NUM_RD | One clock per read port |
| rd_rst_n | input | NUM_RD | Synchronous active-low reset per read port |
| rd_frame_start | input | NUM_RD | One-cycle pulse per port: reader starts a frame |
| rd_slot | output | 2*NUM_RD | Slot index per port, port p at bits [2p+1:2p] |
| rd_addr | output | AW*NUM_RD | Base address per port |
| rd_drop_cnt | output | CNT_W*NUM_RD | Saturating dropped-frame count per port |
| rd_rep_cnt | output | CNT_W*NUM_RD | Saturating repeated-frame count per port |

## Verification
The slot choice is exercised with zero, one, two and several write completions between the start pulses of one port. These cases separate the repeat, advance and skip branches, and show that skipping several frames collapses to a single skip onto the latest slot. Two ports with different clock periods receive start pulses in random order, which would expose any sharing of decision state between ports. Table writes, including writes to the ignored index 3, are mixed in between completions. This shows whether each side applies new addresses at its own frame boundary and not earlier. A long run of repeats on one port drives its counter into saturation.

// File: rtl/tbs_pkg.sv
// Shared types and slot arithmetic for the triple-buffer frame slot arbiter.
// Assumes exactly three slots, encoded 0..2; code 3 never appears on a slot.
package tbs_pkg;
    localparam int NSLOT = 3;

    typedef logic [1:0] slot_t;

    // Next slot in cyclic order 0 -> 1 -> 2 -> 0.
    function automatic slot_t slot_inc(slot_t s);
        return (s == 2'd2) ? 2'd0 : s + 2'd1;
    endfunction
endpackage

// File: rtl/tbs_tog_sync.sv
// Destination half of a toggle pulse synchronizer: two flops resynchronize a
// level that the source flips once per event, and a third flop detects the
// change. Assumes events are spaced by more than three destination cycles.
module tbs_tog_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    logic s1_q, s2_q, s3_q;

    // Resynchronize the toggle and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= tog_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign pulse = s2_q ^ s3_q;
endmodule

// File: rtl/tbs_wr_ctrl.sv
// Write-side controller. It steps the writer through the three slots on each
// frame completion and holds the programmable address table. On every
// completion it publishes the completed slot and a table snapshot, then flips
// a toggle. The published data is stable until the next completion, so read
// domains can capture it on the synchronized toggle edge.
module tbs_wr_ctrl
    import tbs_pkg::*;
#(
    parameter int          AW = 32,
    parameter logic [AW-1:0] BASE0 = '0,
    parameter logic [AW-1:0] BASE1 = '0,
    parameter logic [AW-1:0] BASE2 = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic              cfg_we,
    input  slot_t             cfg_idx,
    input  logic [AW-1:0]     cfg_data,
    output slot_t             slot,
    output logic [AW-1:0]     addr,
    output slot_t             last_slot,
    output logic [3*AW-1:0]   pub_tab,
    output logic              done_tog
);
    localparam logic [3*AW-1:0] TAB_INIT = {BASE2, BASE1, BASE0};

    logic [3*AW-1:0] tab_q;
    slot_t           nxt_slot;

    assign nxt_slot = slot_inc(slot);

    // Table register: an entry changes only on a write to index 0..2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= TAB_INIT;
        end else if (cfg_we) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (cfg_idx == slot_t'(i)) tab_q[i*AW +: AW] <= cfg_data;
            end
        end
    end

    // Writer slot and address advance only at a frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= 2'd0;
            addr <= BASE0;
        end else if (frame_done) begin
            slot <= nxt_slot;
            addr <= tab_q[int'(nxt_slot)*AW +: AW];
        end
    end

    // Publish the completed slot and the table snapshot, then flip the toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_slot <= 2'd2;
            pub_tab   <= TAB_INIT;
            done_tog  <= 1'b0;
        end else if (frame_done) begin
            last_slot <= slot;
            pub_tab   <= tab_q;
            done_tog  <= ~done_tog;
        end
    end

    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> slot == slot_inc($past(slot))); // R2
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(slot) && $stable(addr)); // R8
    AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot != 2'd3); // R2
    AST_WR_PUB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(pub_tab) && $stable(last_slot)); // R9
endmodule

// File: rtl/tbs_rd_port.sv
// One read port, fully in its own clock domain. It captures the last
// completed write slot and the table snapshot when the synchronized
// completion edge arrives. On each frame start it moves to that slot,
// counting a skip or a repeat. It assumes the published data from the write
// side is stable for several read cycles around each toggle edge.
module tbs_rd_port
    import tbs_pkg::*;
#(
    parameter int            AW    = 32,
    parameter int            CNT_W = 16,
    parameter logic [AW-1:0] BASE0 = '0,
    parameter logic [AW-1:0] BASE1 = '0,
    parameter logic [AW-1:0] BASE2 = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              wr_tog,
    input  slot_t             wr_last,
    input  logic [3*AW-1:0]   wr_tab,
    output slot_t             slot,
    output logic [AW-1:0]     addr,
    output logic [CNT_W-1:0]  drop_cnt,
    output logic [CNT_W-1:0]  rep_cnt
);
    localparam logic [CNT_W-1:0] CMAX     = {CNT_W{1'b1}};
    localparam logic [3*AW-1:0]  TAB_INIT = {BASE2, BASE1, BASE0};

    logic            seen_pulse;
    logic            have_l;
    slot_t           l_seen;
    logic [3*AW-1:0] tab_copy;
    logic            is_rep, is_drop;

    tbs_tog_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tog_in (wr_tog),
        .pulse  (seen_pulse)
    );

    // Capture the completed slot and table snapshot on each synchronized edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_l   <= 1'b0;
            l_seen   <= 2'd2;
            tab_copy <= TAB_INIT;
        end else if (seen_pulse) begin
            have_l   <= 1'b1;
            l_seen   <= wr_last;
            tab_copy <= wr_tab;
        end
    end

    // Classify the move: stay on the same slot, or jump two ahead.
    assign is_rep  = (l_seen == slot);
    assign is_drop = (l_seen == slot_inc(slot_inc(slot)));

    // Move to the latest completed slot at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= 2'd2;
            addr <= BASE2;
        end else if (frame_start && have_l) begin
            slot <= l_seen;
            addr <= tab_copy[int'(l_seen)*AW +: AW];
        end
    end

    // Saturating counters of repeated and skipped frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_cnt <= '0;
            rep_cnt  <= '0;
        end else if (frame_start && have_l) begin
            if (is_rep && rep_cnt != CMAX)   rep_cnt  <= rep_cnt + 1'b1;
            if (is_drop && drop_cnt != CMAX) drop_cnt <= drop_cnt + 1'b1;
        end
    end

    AST_RD_AVOID_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && have_l) |=> slot != slot_inc($past(l_seen))); // R5
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !have_l |-> (slot == 2'd2 && drop_cnt == '0 && rep_cnt == '0)); // R3
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(slot) && $stable(addr)); // R9
    AST_DROP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        drop_cnt == CMAX |=> drop_cnt == CMAX); // R7
    AST_REP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        rep_cnt == CMAX |=> rep_cnt == CMAX); // R7
    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_rep && is_drop)); // R4
endmodule

// File: rtl/tbs_frame_sync.sv
// Top level: one write-side controller shared by NUM_RD independent read
// ports. Each read port has its own clock and reset. Per-port outputs are
// packed flat, port p occupying the p-th field of each vector.
module tbs_frame_sync
    import tbs_pkg::*;
#(
    parameter int            NUM_RD = 2,
    parameter int            AW     = 32,
    parameter int            CNT_W  = 16,
    parameter logic [AW-1:0] BASE0  = 32'h1000_0000,
    parameter logic [AW-1:0] BASE1  = 32'h2000_0000,
    parameter logic [AW-1:0] BASE2  = 32'h3000_0000
) (
    input  logic                    wr_clk,
    input  logic                    wr_rst_n,
    input  logic                    wr_frame_done,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_idx,
    input  logic [AW-1:0]           cfg_data,
    output logic [1:0]              wr_slot,
    output logic [AW-1:0]           wr_addr,
    input  logic [NUM_RD-1:0]       rd_clk,
    input  logic [NUM_RD-1:0]       rd_rst_n,
    input  logic [NUM_RD-1:0]       rd_frame_start,
    output logic [2*NUM_RD-1:0]     rd_slot,
    output logic [AW*NUM_RD-1:0]    rd_addr,
    output logic [CNT_W*NUM_RD-1:0] rd_drop_cnt,
    output logic [CNT_W*NUM_RD-1:0] rd_rep_cnt
);
    slot_t           last_slot;
    logic [3*AW-1:0] pub_tab;
    logic            done_tog;

    tbs_wr_ctrl #(
        .AW(AW), .BASE0(BASE0), .BASE1(BASE1), .BASE2(BASE2)
    ) u_wr (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .frame_done (wr_frame_done),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_data   (cfg_data),
        .slot       (wr_slot),
        .addr       (wr_addr),
        .last_slot  (last_slot),
        .pub_tab    (pub_tab),
        .done_tog   (done_tog)
    );

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        tbs_rd_port #(
            .AW(AW), .CNT_W(CNT_W), .BASE0(BASE0), .BASE1(BASE1), .BASE2(BASE2)
        ) u_rd (
            .clk         (rd_clk[g]),
            .rst_n       (rd_rst_n[g]),
            .frame_start (rd_frame_start[g]),
            .wr_tog      (done_tog),
            .wr_last     (last_slot),
            .wr_tab      (pub_tab),
            .slot        (rd_slot[2*g +: 2]),
            .addr        (rd_addr[AW*g +: AW]),
            .drop_cnt    (rd_drop_cnt[CNT_W*g +: CNT_W]),
            .rep_cnt     (rd_rep_cnt[CNT_W*g +: CNT_W])
        );
    end
endmodule

// File: tb/tbs_frame_sync_test.sv
`timescale 1ns/1ps
module tbs_frame_sync_test;
    localparam int NR = 2;
    localparam int AW = 32;
    localparam int CW = 4;
    localparam logic [31:0] B0 = 32'h1000_0000;
    localparam logic [31:0] B1 = 32'h2000_0000;
    localparam logic [31:0] B2 = 32'h3000_0000;
    localparam int CMAX = 15;

    logic wr_clk = 0, rclk0 = 0, rclk1 = 0;
    logic wr_rst_n = 0;
    logic [NR-1:0] rd_rst_n = '0;
    logic wr_frame_done = 0, cfg_we = 0;
    logic [1:0] cfg_idx = 0;
    logic [31:0] cfg_data = 0;
    logic [NR-1:0] rd_frame_start = '0;
    logic [1:0] wr_slot;
    logic [31:0] wr_addr;
    logic [2*NR-1:0] rd_slot;
    logic [AW*NR-1:0] rd_addr;
    logic [CW*NR-1:0] rd_drop_cnt, rd_rep_cnt;

    always #2.5 wr_clk = ~wr_clk;
    always #6.5 rclk0 = ~rclk0;
    always #1.5 rclk1 = ~rclk1;

    tbs_frame_sync #(.NUM_RD(NR), .AW(AW), .CNT_W(CW),
                     .BASE0(B0), .BASE1(B1), .BASE2(B2)) uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_frame_done(wr_frame_done),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .wr_slot(wr_slot), .wr_addr(wr_addr),
        .rd_clk({rclk1, rclk0}), .rd_rst_n(rd_rst_n),
        .rd_frame_start(rd_frame_start), .rd_slot(rd_slot), .rd_addr(rd_addr),
        .rd_drop_cnt(rd_drop_cnt), .rd_rep_cnt(rd_rep_cnt)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    // Bench model
    logic [31:0] tab_m [3];
    logic [31:0] rtab  [NR][3];
    logic [1:0]  wslot, lcomp;
    logic [31:0] waddr;
    bit          lvalid;
    logic [1:0]  rs [NR];
    logic [31:0] ra [NR];
    int          dc [NR], rc [NR];

    function automatic logic [1:0] inc3(logic [1:0] s);
        return (s == 2) ? 2'd0 : s + 2'd1;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_rd(string req);
        for (int p = 0; p < NR; p++) begin
            chk(req, $sformatf("rd_slot[%0d]", p), 32'(rd_slot[2*p +: 2]), 32'(rs[p]));
            chk(req, $sformatf("rd_addr[%0d]", p), rd_addr[AW*p +: AW], ra[p]);
            chk(req, $sformatf("drop[%0d]", p), 32'(rd_drop_cnt[CW*p +: CW]), 32'(dc[p]));
            chk(req, $sformatf("rep[%0d]", p), 32'(rd_rep_cnt[CW*p +: CW]), 32'(rc[p]));
        end
    endtask

    // Write frame completion, then wait long enough for all readers (R10).
    task automatic wr_done();
        @(negedge wr_clk) wr_frame_done = 1;
        @(negedge wr_clk) wr_frame_done = 0;
        lcomp  = wslot;
        lvalid = 1;
        for (int p = 0; p < NR; p++)
            for (int i = 0; i < 3; i++) rtab[p][i] = tab_m[i];
        wslot = inc3(wslot);
        waddr = tab_m[wslot];
        chk("R2", "wr_slot", 32'(wr_slot), 32'(wslot));
        chk("R2", "wr_addr", wr_addr, waddr);
        #160;
    endtask

    task automatic cfg_wr(logic [1:0] idx, logic [31:0] d);
        @(negedge wr_clk) begin cfg_we = 1; cfg_idx = idx; cfg_data = d; end
        @(negedge wr_clk) cfg_we = 0;
        if (idx != 3) tab_m[idx] = d;
        chk("R8", "wr_addr after cfg", wr_addr, waddr);
    endtask

    task automatic rd_start(int p);
        if (p == 0) @(negedge rclk0); else @(negedge rclk1);
        rd_frame_start[p] = 1'b1;
        if (p == 0) @(negedge rclk0); else @(negedge rclk1);
        rd_frame_start[p] = 1'b0;
        if (lvalid) begin
            if (lcomp == rs[p]) begin if (rc[p] < CMAX) rc[p]++; end
            else if (lcomp == inc3(inc3(rs[p]))) begin if (dc[p] < CMAX) dc[p]++; end
            rs[p] = lcomp;
            ra[p] = rtab[p][lcomp];
            checks++;
            if (rd_slot[2*p +: 2] == inc3(lcomp)) begin
                failures++;
                $display("FAIL R5 port %0d on writer slot actual=%0d expected!=%0d",
                         p, rd_slot[2*p +: 2], inc3(lcomp));
            end
        end
        chk_rd(lvalid ? "R4/R6" : "R3");
        #20;
    endtask

    initial begin
        #5ms;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        tab_m[0] = B0; tab_m[1] = B1; tab_m[2] = B2;
        wslot = 0; waddr = B0; lcomp = 2; lvalid = 0;
        for (int p = 0; p < NR; p++) begin
            rs[p] = 2; ra[p] = B2; dc[p] = 0; rc[p] = 0;
            for (int i = 0; i < 3; i++) rtab[p][i] = tab_m[i];
        end
        #300;
        @(negedge wr_clk) begin wr_rst_n = 1; rd_rst_n = '1; end
        #100;
        // R1 reset state
        chk("R1", "wr_slot", 32'(wr_slot), 0);
        chk("R1", "wr_addr", wr_addr, B0);
        chk_rd("R1");
        // R3: start before any write completion
        rd_start(0);
        rd_start(1);
        // R4 advance, R6 independence
        wr_done();
        rd_start(0);
        // R4 repeat
        rd_start(0);
        // R4 skip on port 0, repeat on port 1
        wr_done();
        wr_done();
        rd_start(0);
        rd_start(1);
        // R8 table write (applied at next completion) and ignored index 3
        cfg_wr(2'd1, 32'hA1A1_0000);
        cfg_wr(2'd3, 32'hDEAD_BEEF);
        wr_done();
        wr_done();
        wr_done();
        rd_start(0);  // R9 address from snapshot
        rd_start(1);
        // R7 saturation of repeat counter
        for (int k = 0; k < 18; k++) rd_start(1);
        chk("R7", "rep saturated", 32'(rd_rep_cnt[CW +: CW]), CMAX);
        // Random mix
        for (int k = 0; k < 150; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4) wr_done();
            else if (op < 8) rd_start(op % 2);
            else cfg_wr(2'($urandom_range(0, 3)), $urandom);
        end
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule